// File: doc/BRIEF.md
# Delta-Sigma Bitstream Modulator

This block converts one N-bit code into a frame of single-bit pulses whose count of ones equals the code. A downstream switched current source can then charge a capacitor once for every high bit and settle on a voltage proportional to the code. Inside is an (N+2)-bit accumulator. Two chained adders update it on every clock: the first adds a feedback word to the zero-extended input code, and the second adds that sum to the accumulator. The feedback word depends only on the accumulator's top bit.

A conversion starts with a single-cycle strobe while the block is idle. The code is held in a register for the whole frame. The block then spends one cycle on initialisation, with the output not flagged as valid. After that it streams 2^N valid bits, one per clock. The frame has no back-pressure. The consumer must take every bit in the cycle that `bit_valid` is high, because the integrator it feeds is timed by the clock and cannot stall. A pulse on `frame_done` marks the last bit of the frame, and the block becomes idle on the next cycle.

Top module: `dsm_bitstream_mod`

## Requirements
- R1: The accumulator is N+2 bits wide. It holds the preset value, a one in its MSB and zeros below, in every idle cycle and in the initialisation cycle.
- R2: The feedback word is zero when the accumulator MSB is 0. When the MSB is 1, the feedback word has ones in its top two bit positions and zeros in the N bits below.
- R3: On every non-idle clock, the next accumulator value is (accumulator + feedback + zero-extended code) mod 2^(N+2). For N=3 and code 3, the valid bits of a frame are, in order, 0,0,1,0,0,1,0,1.
- R4: During a frame, `bit_out` equals the accumulator MSB.
- R5: In the cycle after an accepted start, `bit_valid` is 0 and `bit_out` is 1, which is the MSB of the preset value.
- R6: `bit_valid` is then high for exactly 2^N consecutive cycles.
- R7: The number of ones among the valid bits of a frame equals the captured code, for every code from 0 to 2^N-1.
- R8: `frame_done` is a one-cycle pulse that coincides with the last valid bit. In the cycle after it, both `bit_valid` and `frame_done` are low.
- R9: `din` is sampled only on an accepted start. Changes on `din` during a frame do not alter that frame's bits.
- R10: A `start` that arrives during a frame, including the initialisation cycle, is ignored. It neither restarts nor lengthens the frame.
- R11: A synchronous reset (`rst` high at a rising edge) leaves `bit_valid`, `frame_done` and `bit_out` low and puts the block in the idle state, even if a frame was in progress.
- R12: While idle, `bit_out` is 0. Because every frame begins from the preset value, two frames with the same code produce identical bit sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request; accepted only while idle |
| din | input | N | Code to convert, sampled on an accepted start |
| bit_out | output | 1 | Serial pulse output |
| bit_valid | output | 1 | High while `bit_out` carries a frame bit |
| frame_done | output | 1 | One-cycle pulse on the last valid bit |

## Verification
The assertions assume that `start` is sampled synchronously and that `rst` is held for at least one rising edge. They make no assumption about how often `start` is raised or how `din` moves during a frame. The bench deliberately holds `start` high for entire frames and toggles `din` at random during conversions. This places the ignore and capture rules under the same stimulus the assertions watch. Codes come from a seeded generator, and the directed cases add both ends of the code range and a reset issued in the middle of a frame.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_RUN  = 2'd2
  } dsm_phase_t;
endpackage

// File: rtl/dsm_adder.sv
// Modulo-2^W adder; RIPPLE selects an explicit carry chain or an inferred adder.
module dsm_adder #(
  parameter int W      = 5,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  generate
    if (RIPPLE) begin : g_ripple
      logic [W-1:0] c;
      assign c[0] = 1'b0;
      for (genvar g = 0; g < W; g++) begin : g_cell
        assign s[g] = a[g] ^ b[g] ^ c[g];
        if (g < W - 1) begin : g_carry
          assign c[g+1] = (a[g] & b[g]) | (c[g] & (a[g] ^ b[g]));
        end
      end
    end else begin : g_infer
      assign s = a + b;
    end
  endgenerate
endmodule

// File: rtl/dsm_feedback_gen.sv
// Feedback word: top two bits copy the accumulator MSB, the rest are zero.
module dsm_feedback_gen #(
  parameter int ACC_W = 5
) (
  input  logic             msb,
  output logic [ACC_W-1:0] fb
);
  localparam int LOW_W = ACC_W - 2;
  assign fb = {msb, msb, {LOW_W{1'b0}}};
endmodule

// File: rtl/dsm_accum.sv
// Accumulator register with its two-adder update path.
module dsm_accum #(
  parameter int N      = 3,
  parameter bit RIPPLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload,
  input  logic [N-1:0] code,
  output logic [N+1:0] acc
);
  localparam int ACC_W = N + 2;
  localparam logic [ACC_W-1:0] PRESET = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] fb;
  logic [ACC_W-1:0] code_ext;
  logic [ACC_W-1:0] fb_plus_code;
  logic [ACC_W-1:0] acc_next;

  assign code_ext = {2'b00, code};

  dsm_feedback_gen #(.ACC_W(ACC_W)) fb_i (
    .msb (acc[ACC_W-1]),
    .fb  (fb)
  );

  dsm_adder #(.W(ACC_W), .RIPPLE(RIPPLE)) add_fb_i (
    .a (fb),
    .b (code_ext),
    .s (fb_plus_code)
  );

  dsm_adder #(.W(ACC_W), .RIPPLE(RIPPLE)) add_acc_i (
    .a (fb_plus_code),
    .b (acc),
    .s (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst || reload) acc <= PRESET;
    else               acc <= acc_next;
  end
endmodule

// File: rtl/dsm_frame_ctrl.sv
// Frame sequencer: idle, one initialisation cycle, then 2^N valid bits.
module dsm_frame_ctrl
  import dsm_pkg::*;
#(
  parameter int N = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output dsm_phase_t phase,
  output logic       capture,
  output logic       reload,
  output logic       valid,
  output logic       last
);
  localparam logic [N-1:0] LAST_IDX = {N{1'b1}};

  logic [N-1:0] idx;

  assign capture = (phase == PH_IDLE) && start;
  assign valid   = (phase == PH_RUN);
  assign last    = valid && (idx == LAST_IDX);
  assign reload  = (phase == PH_IDLE) || last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_INIT;
        PH_INIT: begin
          phase <= PH_RUN;
          idx   <= '0;
        end
        PH_RUN: begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsm_bitstream_mod.sv
module dsm_bitstream_mod
  import dsm_pkg::*;
#(
  parameter int N          = 3,
  parameter bit RIPPLE_ADD = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] din,
  output logic         bit_out,
  output logic         bit_valid,
  output logic         frame_done
);
  localparam int ACC_W = N + 2;

  dsm_phase_t       phase;
  logic             capture;
  logic             reload;
  logic [N-1:0]     code_q;
  logic [ACC_W-1:0] acc;

  dsm_frame_ctrl #(.N(N)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .phase   (phase),
    .capture (capture),
    .reload  (reload),
    .valid   (bit_valid),
    .last    (frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst)          code_q <= '0;
    else if (capture) code_q <= din;
  end

  dsm_accum #(.N(N), .RIPPLE(RIPPLE_ADD)) accum_i (
    .clk    (clk),
    .rst    (rst),
    .reload (reload),
    .code   (code_q),
    .acc    (acc)
  );

  assign bit_out = (phase != PH_IDLE) && acc[ACC_W-1];
endmodule

// File: rtl/dsm_bitstream_mod_chk.sv
module dsm_bitstream_mod_chk
  import dsm_pkg::*;
#(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         bit_out,
  input logic         bit_valid,
  input logic         frame_done,
  input dsm_phase_t   phase,
  input logic [N-1:0] code_q,
  input logic [N+1:0] acc
);
  localparam int FRAME_LEN = 1 << N;
  localparam logic [N+1:0] PRESET = {1'b1, {(N+1){1'b0}}};

  logic [N:0] vcnt;
  logic [N:0] ones;

  always_ff @(posedge clk) begin
    if (rst || !bit_valid) begin
      vcnt <= '0;
      ones <= '0;
    end else begin
      vcnt <= vcnt + 1'b1;
      ones <= ones + {{N{1'b0}}, bit_out};
    end
  end

  // R1: preset held while idle and in the initialisation cycle
  p_preset_r1: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_RUN) |-> (acc == PRESET));
  // R4: output follows accumulator MSB during a frame
  p_msb_out_r4: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (bit_out == acc[N+1]));
  p_init_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INIT) |-> (bit_out && !bit_valid));
  p_run_len_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (vcnt == (N+1)'(FRAME_LEN - 1)));
  p_run_cont_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !frame_done) |=> bit_valid);
  p_ones_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ((ones + {{N{1'b0}}, bit_out}) == {1'b0, code_q}));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (!bit_valid && !frame_done));
  p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |-> $stable(code_q));
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN && !frame_done) |=> (phase == PH_RUN));
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!bit_valid && !frame_done && !bit_out));
  p_idle_low_r12: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (!bit_out && !bit_valid));
endmodule

bind dsm_bitstream_mod dsm_bitstream_mod_chk #(.N(N)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bit_out    (bit_out),
  .bit_valid  (bit_valid),
  .frame_done (frame_done),
  .phase      (phase),
  .code_q     (code_q),
  .acc        (acc)
);

// File: tb/dsm_bitstream_mod_tb_top.sv
module dsm_bitstream_mod_tb_top;
  localparam int N          = 3;
  localparam int FRAME_LEN  = 1 << N;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] din = '0;
  logic         bit_out, bit_valid, frame_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsm_bitstream_mod #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .din(din),
    .bit_out(bit_out), .bit_valid(bit_valid), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int popcnt(input logic [FRAME_LEN-1:0] v);
    int c = 0;
    for (int i = 0; i < FRAME_LEN; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One frame; bits[i] is the i-th valid bit. hold_start keeps start high (R10),
  // wiggle changes din every cycle of the frame (R9).
  task automatic run_frame(input int code, input bit hold_start, input bit wiggle,
                           output logic [FRAME_LEN-1:0] bits);
    bits = '0;
    @(negedge clk);
    start = 1'b1;
    din   = N'(code);
    @(negedge clk);
    // R5: initialisation cycle
    chk(!bit_valid, "R5 init valid", int'(bit_valid), 0);
    chk(bit_out, "R5 init bit", int'(bit_out), 1);
    start = hold_start;
    if (wiggle) din = N'($urandom);
    for (int i = 0; i < FRAME_LEN; i++) begin
      @(negedge clk);
      chk(bit_valid, "R6 valid run", int'(bit_valid), 1);
      chk(frame_done == (i == FRAME_LEN - 1), "R8 done timing", int'(frame_done),
          int'(i == FRAME_LEN - 1));
      bits[i] = bit_out;
      if (wiggle) din = N'($urandom);
    end
    start = 1'b0;
    @(negedge clk);
    chk(!bit_valid && !frame_done, "R8 after done", int'(bit_valid) + int'(frame_done), 0);
    chk(!bit_out, "R12 idle low", int'(bit_out), 0);
    chk(popcnt(bits) == code, "R7 ones count", popcnt(bits), code);
  endtask

  initial begin
    for (int c = 0; c < WD_CYCLES; c++) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
    finish_run();
  end

  initial begin
    logic [FRAME_LEN-1:0] bits, ref_bits;
    logic [7:0] exp3;
    int dummy;
    dummy = $urandom(32'd1234);
    // R11: reset state
    repeat (3) @(negedge clk);
    chk(!bit_valid && !frame_done && !bit_out, "R11 reset outputs",
        int'(bit_valid) + int'(frame_done) + int'(bit_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bit_out && !bit_valid, "R12 idle after reset", int'(bit_out), 0);

    // R1 R2 R3 R4: exact sequence for code 3 (bit 0 first)
    exp3 = 8'b1010_0100;
    run_frame(3, 1'b0, 1'b0, bits);
    if (N == 3) chk(bits == FRAME_LEN'(exp3), "R3 code3 sequence", int'(bits), int'(exp3));
    ref_bits = bits;
    // R12: re-initialisation gives identical frame
    run_frame(3, 1'b0, 1'b0, bits);
    chk(bits == ref_bits, "R12 repeat frame", int'(bits), int'(ref_bits));
    // R9: din wiggled during frame
    run_frame(3, 1'b0, 1'b1, bits);
    chk(bits == ref_bits, "R9 din ignored", int'(bits), int'(ref_bits));
    // R10: start held through frame
    run_frame(3, 1'b1, 1'b0, bits);
    chk(bits == ref_bits, "R10 start ignored", int'(bits), int'(ref_bits));

    // Range ends R7
    run_frame(0, 1'b0, 1'b0, bits);
    run_frame(FRAME_LEN - 1, 1'b0, 1'b0, bits);
    run_frame(1, 1'b0, 1'b0, bits);

    // Random frames
    for (int k = 0; k < 40; k++) begin
      run_frame(int'($urandom % FRAME_LEN), 1'($urandom), 1'($urandom), bits);
    end

    // R11: reset mid-frame
    @(negedge clk);
    start = 1'b1; din = N'(5);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!bit_valid && !frame_done && !bit_out, "R11 mid-frame reset",
        int'(bit_valid) + int'(frame_done) + int'(bit_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bit_valid, "R11 stays idle", int'(bit_valid), 0);
    run_frame(3, 1'b0, 1'b0, bits);
    chk(bits == ref_bits, "R11 clean frame after reset", int'(bits), int'(ref_bits));

    finish_run();
  end
endmodule